// File: doc/BRIEF.md
# Multi-Source Reset Domain Controller

This block merges three reset sources of a network controller into separate reset enables, one for each group of registers. The sources are an asynchronous hardware reset pin, a software reset bit in a configuration-option register, and a soft-reset bit in a receive-control register. Each source clears its own set of state. The option register survives everything except the hardware pin. The address, configuration and base registers also survive the receive-control soft reset. The core register is cleared by all three sources.

Only a hardware reset captures the bus-mode strap pins and issues a one-cycle start request to a serial EEPROM loader. After the request, the core stays in reset for as long as the loader reports busy. While the software reset bit is set, the shared interrupt/ready output is held low. All domain resets are synchronous enables. The hardware pin asserts them at once and releases them on a clock edge through a synchronizer.

Software reaches six byte registers through one synchronous bus with a single address. Writes take effect on the clock edge. The read data is combinational from the address.

Top module: `rst_domain_ctrl`

## Requirements
- R1: While the synchronized hardware reset is active, `rst_all`, `rst_persist` and `rst_core` are 1. From the first clock edge of that reset, every register reads 0. The register map is: 0 = option, 1 = receive control, 2 = address, 3 = configuration, 4 = base, 5 = core. Any other address reads 0.
- R2: `rst_all` and `rst_persist` fall on the SYNC_STAGES-th rising clock edge after `hw_rst_n` goes high.
- R3: In the cycle just after that release, `strap_sample` and `ee_load_req` are both 1 for exactly one cycle. At the end of that cycle, `mode_latched` captures `mode_strap`.
- R4: `rst_core` stays 1 during the request cycle. After it, `rst_core` stays 1 for as long as `ee_busy` is 1, and falls in the same cycle that `ee_busy` falls.
- R5: After bit 0 of the option register is written with 1, `rst_persist` and `rst_core` are 1. Registers 1 to 5 read 0, and writes to them are ignored. The option register keeps the written value, including bit 0.
- R6: `irq_rdy` is 0 while option bit 0 is 1. Otherwise `irq_rdy` equals `irq_src`.
- R7: Receive-control bit 0 set to 1 holds `rst_core` at 1 and clears the core register, which then ignores writes. The address, configuration and base registers keep their values. Clearing the bit releases the core.
- R8: A hardware reset clears option bit 0 and receive-control bit 0 even while they are set, and it overrides the other sources.
- R9: Neither the software reset nor the soft reset pulses `strap_sample` or `ee_load_req`, and neither changes `mode_latched`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register |
| mode_strap | input | MODE_W | Bus-mode strap pins |
| mode_latched | output | MODE_W | Strap value captured by hardware reset |
| strap_sample | output | 1 | Strap capture pulse |
| ee_load_req | output | 1 | EEPROM load start pulse |
| ee_busy | input | 1 | EEPROM loader busy |
| irq_src | input | 1 | Interrupt/ready level from the controller |
| irq_rdy | output | 1 | Shared interrupt/ready output |
| rst_all | output | 1 | Hardware-only reset domain enable |
| rst_persist | output | 1 | Address/configuration/base domain reset enable |
| rst_core | output | 1 | Core domain reset enable |

## Verification
The bench builds the block with SYNC_STAGES = 3, DATA_W = 8 and MODE_W = 2. The deeper synchronizer means the release edge count in R2 shows whether the stage parameter is honoured, rather than a fixed two-flop delay. The 8-bit registers allow patterns in which bit 0 and the upper bits are set independently. This shows that only bit 0 acts as a reset control while the other bits are stored.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
   localparam int NUM_REGS = 6;
   localparam int REG_OPT  = 0;
   localparam int REG_RXC  = 1;
   localparam int REG_IDA  = 2;
   localparam int REG_CFG  = 3;
   localparam int REG_BASE = 4;
   localparam int REG_CORE = 5;

   typedef enum logic [1:0] {
      CLS_HW      = 2'd0,
      CLS_PERSIST = 2'd1,
      CLS_CORE    = 2'd2
   } rst_class_e;

   function automatic rst_class_e reg_class(input int idx);
      if (idx == REG_OPT)       return CLS_HW;
      else if (idx == REG_CORE) return CLS_CORE;
      else                      return CLS_PERSIST;
   endfunction
endpackage

// File: rtl/rdc_rst_sync.sv
module rdc_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic sync_n
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rdc_reset_merge.sv
module rdc_reset_merge #(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              hw_sync_n,
   input  logic              sw_hold,
   input  logic              soft_hold,
   input  logic              ee_busy,
   input  logic [MODE_W-1:0] mode_strap,
   output logic              hw_rst,
   output logic              persist_rst,
   output logic              core_rst,
   output logic              load_pulse,
   output logic [MODE_W-1:0] mode_q
);
   logic released_q;

   always_ff @(posedge clk) begin
      released_q <= hw_sync_n;
   end

   assign hw_rst      = ~hw_sync_n;
   assign load_pulse  = hw_sync_n & ~released_q;
   assign persist_rst = hw_rst | sw_hold;
   assign core_rst    = persist_rst | soft_hold | load_pulse | ee_busy;

   always_ff @(posedge clk) begin
      if (hw_rst)          mode_q <= '0;
      else if (load_pulse) mode_q <= mode_strap;
   end
endmodule

// File: rtl/rdc_regfile.sv
module rdc_regfile
   import rdc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_hw,
   input  logic              rst_persist,
   input  logic              rst_core,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] opt_q,
   output logic [DATA_W-1:0] rxc_q
);
   logic [NUM_REGS-1:0][DATA_W-1:0] bank;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam rst_class_e CLS = reg_class(i);
      logic              clr;
      logic [DATA_W-1:0] q;

      if (CLS == CLS_HW) begin : g_hw
         assign clr = rst_hw;
      end else if (CLS == CLS_PERSIST) begin : g_persist
         assign clr = rst_persist;
      end else begin : g_core
         assign clr = rst_core;
      end

      always_ff @(posedge clk) begin
         if (clr)                                 q <= '0;
         else if (wr_en && addr == ADDR_W'(i))    q <= wr_data;
      end

      assign bank[i] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (addr == ADDR_W'(k)) rd_data = bank[k];
      end
   end

   assign opt_q = bank[REG_OPT];
   assign rxc_q = bank[REG_RXC];
endmodule

// File: rtl/rst_domain_ctrl.sv
module rst_domain_ctrl
   import rdc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 3,
   parameter int MODE_W      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int SWRST_BIT   = 0,
   parameter int SOFT_BIT    = 0
) (
   input  logic              clk,
   input  logic              hw_rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [MODE_W-1:0] mode_strap,
   output logic [MODE_W-1:0] mode_latched,
   output logic              strap_sample,
   output logic              ee_load_req,
   input  logic              ee_busy,
   input  logic              irq_src,
   output logic              irq_rdy,
   output logic              rst_all,
   output logic              rst_persist,
   output logic              rst_core
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end
   if (SWRST_BIT >= DATA_W || SOFT_BIT >= DATA_W) begin : g_bad_bit
      $error("reset control bit outside the data width");
   end
   if (MODE_W < 1) begin : g_bad_mode
      $error("MODE_W must be at least 1");
   end

   logic              hw_sync_n;
   logic              load_pulse;
   logic [DATA_W-1:0] opt_q;
   logic [DATA_W-1:0] rxc_q;

   rdc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (hw_rst_n),
      .sync_n (hw_sync_n)
   );

   rdc_reset_merge #(.MODE_W(MODE_W)) u_merge (
      .clk         (clk),
      .hw_sync_n   (hw_sync_n),
      .sw_hold     (opt_q[SWRST_BIT]),
      .soft_hold   (rxc_q[SOFT_BIT]),
      .ee_busy     (ee_busy),
      .mode_strap  (mode_strap),
      .hw_rst      (rst_all),
      .persist_rst (rst_persist),
      .core_rst    (rst_core),
      .load_pulse  (load_pulse),
      .mode_q      (mode_latched)
   );

   rdc_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk         (clk),
      .rst_hw      (rst_all),
      .rst_persist (rst_persist),
      .rst_core    (rst_core),
      .wr_en       (bus_wr),
      .addr        (bus_addr),
      .wr_data     (bus_wdata),
      .rd_data     (bus_rdata),
      .opt_q       (opt_q),
      .rxc_q       (rxc_q)
   );

   assign strap_sample = load_pulse;
   assign ee_load_req  = load_pulse;
   assign irq_rdy      = opt_q[SWRST_BIT] ? 1'b0 : irq_src;
endmodule

// File: rtl/rdc_checker.sv
module rdc_checker #(
   parameter int MODE_W = 2
) (
   input logic              clk,
   input logic              hw_rst_n,
   input logic              sw_bit,
   input logic              soft_bit,
   input logic              core_rst,
   input logic              persist_rst,
   input logic              ee_load_req,
   input logic              strap_sample,
   input logic              ee_busy,
   input logic              irq_rdy,
   input logic [MODE_W-1:0] mode_latched
);
   // R3
   load_single_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      ee_load_req |=> !ee_load_req);
   // R3
   strap_with_load_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      strap_sample |-> ee_load_req);
   // R4
   busy_hold_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      ee_busy |-> core_rst);
   // R5
   sw_hold_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      sw_bit |-> (core_rst && persist_rst));
   // R6
   irq_low_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      sw_bit |-> !irq_rdy);
   // R9
   soft_no_load_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (soft_bit || sw_bit) |-> !ee_load_req);
   // R9
   mode_stable_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
      !strap_sample |=> $stable(mode_latched));
endmodule

bind rst_domain_ctrl rdc_checker #(.MODE_W(MODE_W)) u_chk (
   .clk          (clk),
   .hw_rst_n     (hw_rst_n),
   .sw_bit       (opt_q[SWRST_BIT]),
   .soft_bit     (rxc_q[SOFT_BIT]),
   .core_rst     (rst_core),
   .persist_rst  (rst_persist),
   .ee_load_req  (ee_load_req),
   .strap_sample (strap_sample),
   .ee_busy      (ee_busy),
   .irq_rdy      (irq_rdy),
   .mode_latched (mode_latched)
);

// File: tb/rst_domain_ctrl_bench.sv
`timescale 1ns/1ps
module rst_domain_ctrl_bench;
   localparam int DW = 8;
   localparam int AW = 3;
   localparam int MW = 2;
   localparam int SS = 3;

   logic          clk = 0;
   logic          hw_rst_n = 0;
   logic          bus_wr = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [MW-1:0] mode_strap = 2'b10;
   logic [MW-1:0] mode_latched;
   logic          strap_sample, ee_load_req, irq_rdy;
   logic          ee_busy = 0;
   logic          irq_src = 1;
   logic          rst_all, rst_persist, rst_core;

   int checks = 0;
   int fails = 0;
   int pulses = 0;
   int pulse_mark;

   typedef struct {
      logic [DW-1:0] exp;
      string         what;
   } rd_item_t;
   rd_item_t rq[$];

   always #5 clk = ~clk;

   rst_domain_ctrl #(.DATA_W(DW), .ADDR_W(AW), .MODE_W(MW), .SYNC_STAGES(SS))
   u_rst_domain_ctrl (
      .clk(clk), .hw_rst_n(hw_rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_strap(mode_strap),
      .mode_latched(mode_latched), .strap_sample(strap_sample),
      .ee_load_req(ee_load_req), .ee_busy(ee_busy), .irq_src(irq_src),
      .irq_rdy(irq_rdy), .rst_all(rst_all), .rst_persist(rst_persist),
      .rst_core(rst_core)
   );

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   always @(negedge clk) if (ee_load_req || strap_sample) pulses++;

   // monitor: pops expected read items and compares
   always @(posedge clk) begin
      #2;
      if (rq.size() > 0) begin
         rd_item_t it;
         it = rq.pop_front();
         check(it.what, 32'(bus_rdata), 32'(it.exp));
      end
   end

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = AW'(a); bus_wdata = d; bus_wr = 1;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(input int a, input logic [DW-1:0] e, input string what);
      @(negedge clk);
      bus_addr = AW'(a);
      rq.push_back('{exp: e, what: what});
      @(posedge clk);
      #3;
   endtask

   task automatic release_hw(input string what);
      int n = 0;
      @(negedge clk);
      hw_rst_n = 1;
      while (rst_persist && n < 10) begin
         @(posedge clk); #1; n++;
      end
      check({what, " R2 release edges"}, n, SS);
      check("R2 rst_all released", rst_all, 0);
      check("R3 strap_sample pulse", strap_sample, 1);
      check("R3 ee_load_req pulse", ee_load_req, 1);
      check("R4 core held in request cycle", rst_core, 1);
   endtask

   initial begin
      #2_000_000;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 rst_all in reset", rst_all, 1);
      check("R1 rst_persist in reset", rst_persist, 1);
      check("R1 rst_core in reset", rst_core, 1);
      check("R1 no load request in reset", ee_load_req, 0);
      for (int a = 0; a < 8; a++) rd(a, 8'h00, "R1 register zero in reset");

      release_hw("first");
      @(negedge clk); ee_busy = 1;
      @(posedge clk); #1;
      check("R3 strap pulse single cycle", strap_sample, 0);
      check("R3 load pulse single cycle", ee_load_req, 0);
      check("R3 mode captured", mode_latched, 2'b10);
      repeat (4) @(posedge clk);
      #1 check("R4 core held while busy", rst_core, 1);
      check("R4 persist free while busy", rst_persist, 0);
      @(negedge clk); ee_busy = 0; #1;
      check("R4 core released with busy", rst_core, 0);

      wr(2, 8'h5A); wr(3, 8'h3C); wr(4, 8'hC3); wr(5, 8'h77); wr(1, 8'h40);
      mode_strap = 2'b01;
      rd(2, 8'h5A, "R1 address reg write"); rd(5, 8'h77, "R1 core reg write");
      rd(6, 8'h00, "R1 unmapped address");

      // soft reset through receive control
      pulse_mark = pulses;
      wr(1, 8'h41);
      @(posedge clk); #1 check("R7 core held by soft bit", rst_core, 1);
      check("R7 persist free under soft bit", rst_persist, 0);
      rd(5, 8'h00, "R7 core cleared"); rd(2, 8'h5A, "R7 address kept");
      rd(3, 8'h3C, "R7 config kept"); rd(4, 8'hC3, "R7 base kept");
      rd(1, 8'h41, "R7 rxc bit readable");
      wr(5, 8'h11); rd(5, 8'h00, "R7 core write ignored");
      check("R9 mode unchanged by soft reset", mode_latched, 2'b10);
      check("R9 no pulse in soft reset", pulses, pulse_mark);
      wr(1, 8'h40); #1 check("R7 core released", rst_core, 0);
      wr(5, 8'h22); rd(5, 8'h22, "R7 core writable again");

      // software reset through option register
      wr(0, 8'h81);
      #1 check("R5 persist held", rst_persist, 1);
      check("R5 core held", rst_core, 1);
      check("R6 irq low under sw reset", irq_rdy, 0);
      rd(0, 8'h81, "R5 option bit survives");
      rd(1, 8'h00, "R5 rxc cleared"); rd(2, 8'h00, "R5 address cleared");
      rd(3, 8'h00, "R5 config cleared"); rd(4, 8'h00, "R5 base cleared");
      rd(5, 8'h00, "R5 core cleared");
      wr(2, 8'h99); rd(2, 8'h00, "R5 write ignored");
      check("R9 mode unchanged by sw reset", mode_latched, 2'b10);
      check("R9 no pulse in sw reset", pulses, pulse_mark);
      wr(0, 8'h80);
      #1 check("R6 irq raised on clear", irq_rdy, 1);
      check("R5 persist released", rst_persist, 0);
      irq_src = 0; #1 check("R6 irq follows source", irq_rdy, 0);
      irq_src = 1;

      // hardware reset overrides active sources
      wr(1, 8'h01); wr(0, 8'h01);
      @(negedge clk); hw_rst_n = 0; #1;
      check("R8 rst_all immediate", rst_all, 1);
      repeat (2) @(posedge clk);
      rd(0, 8'h00, "R8 option cleared by hw");
      rd(1, 8'h00, "R8 rxc cleared by hw");
      pulse_mark = pulses;
      release_hw("second");
      @(posedge clk); #1;
      check("R8 mode recaptured", mode_latched, 2'b01);
      check("R8 one pulse per hw reset", pulses, pulse_mark + 1);
      check("R8 core free with no busy", rst_core, 0);
      check("R8 irq high after hw", irq_rdy, 1);

      repeat (3) @(posedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule